// File: doc/BRIEF.md
# Core Module System Control Registers

This block is the control and identity register file of a processor core module. Software reads and writes it one 32-bit word at a time over a simple register bus. Each access carries a byte address, a write enable with write data, or a read strobe. The register is picked by the byte address divided by four. Read data is registered: it appears in the cycle after the read strobe and holds until the next read.

The block holds a fixed identity word, a status constant, two oscillator settings, a small control register, the SDRAM and init settings, and two flag registers. Each flag register has its own set address and clear address. The oscillator settings are protected by a 16-bit unlock key. The control register drives two outputs: a one-cycle reset-request pulse, and a remap level that chooses flash or RAM at address zero. A read-only byte window exposes a serial-presence-detect table. The memory size in megabytes is a parameter. It sets both the size code in the SDRAM reset value and one byte of the presence-detect table.

Top module: `core_ctrl_regs`

## Requirements
- R1: Reads are registered. The value appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read. Word 0 reads 0x411A3001, word 1 reads 0, and word 4 reads 0x00100000.
- R2: After reset: word 2 (oscillator) reads 0x01000048, word 7 (auxiliary oscillator) reads 0x0007FEFF, word 9 (init) reads 0x00000112, and word 3, word 5, word 12 and word 14 read 0. Word 8 (SDRAM) reads 0x00011122 ORed with a size code. The size code is 0x10 for MEM_MB of 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more, and 0 below 32. With the default MEM_MB of 128, word 8 reads 0x0001112E.
- R3: A write to word 5 stores bits 15:0 of the data. A read of word 5 returns 0x1A05F when the stored value is 0xA05F, and returns the stored value otherwise.
- R4: Writes to word 2 and word 7 take effect only while word 5 holds 0xA05F. At any other time they are dropped.
- R5: Word 3 stores only bits 0 and 2; all its other bits read 0. Writing data with bit 3 set drives `reset_req` high for exactly one cycle, starting with the clock edge that takes the write.
- R6: `remap_ram` follows bit 2 of word 3. A 0 selects flash at address zero and a 1 selects RAM.
- R7: A write to word 12 ORs the data into the flags. A write to word 13 clears the flag bits that are 1 in the data. A read of word 12 returns the flags.
- R8: The non-volatile flags work the same way through words 14 (set and read) and 15 (clear), and are independent of the word 12 flags.
- R9: Word 8 and word 9 store and return all 32 bits written.
- R10: A read at byte offset 0x100 + 4*i, for i from 0 to 31, returns table byte i in bits 7:0 with zeros above. Bytes 0 to 30 are 0x80, 0x08, 0x04, 0x0B, 0x09, 0x01, 0x40, 0x00, 0x02, 0xA0, 0xA0, 0x00, 0x00, 0x08, 0x00, 0x01, 0x0E, 0x04, 0x1C, 0x01, 0x02, 0x20, 0xC0, 0x00, 0x00, 0x00, 0x00, 0x30, 0x28, 0x30, 0x28. Byte 31 is 64, 32, 16, 4 or 2 for the same MEM_MB thresholds as in R2 (32 by default). Offsets 0x180 to 0x1FF read 0, and writes to the window are ignored.
- R11: Words 32 to 35 and every unassigned offset read 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| reset_req | output | 1 | One-cycle system reset request |
| remap_ram | output | 1 | 1 = RAM at address zero, 0 = boot flash |

## Verification
The assertions check, on every cycle, that the read data holds between read strobes and that the remap level changes only after a write. They also check that every reset-request pulse lasts one cycle and follows a write with bit 3 set, that the identity word is correct, and that the lock readback never exceeds 17 bits. Only the bench scenarios can show the reset values and the lock key actually gating the oscillator writes. The same goes for the set and clear arithmetic of the two flag registers, the presence-detect bytes derived from the size parameter, and writes to unassigned offsets leaving the real registers unchanged.

// File: rtl/cmctl_pkg.sv
package cmctl_pkg;

    localparam logic [31:0] ID_VALUE    = 32'h411A_3001;
    localparam logic [31:0] STAT_VALUE  = 32'h0010_0000;
    localparam logic [15:0] UNLOCK_KEY  = 16'hA05F;
    localparam logic [31:0] OSC_RST     = 32'h0100_0048;
    localparam logic [31:0] AUXOSC_RST  = 32'h0007_FEFF;
    localparam logic [31:0] INIT_RST    = 32'h0000_0112;
    localparam logic [31:0] SDRAM_BASE  = 32'h0001_1122;

    localparam int unsigned W_ID      = 0;
    localparam int unsigned W_PROC    = 1;
    localparam int unsigned W_OSC     = 2;
    localparam int unsigned W_CTRL    = 3;
    localparam int unsigned W_STAT    = 4;
    localparam int unsigned W_LOCK    = 5;
    localparam int unsigned W_AUXOSC  = 7;
    localparam int unsigned W_SDRAM   = 8;
    localparam int unsigned W_INIT    = 9;
    localparam int unsigned W_FLG_SET = 12;
    localparam int unsigned W_FLG_CLR = 13;
    localparam int unsigned W_NVF_SET = 14;
    localparam int unsigned W_NVF_CLR = 15;

    localparam int unsigned SPD_ENTRIES = 32;

    // SDRAM size code from memory size in MB
    function automatic logic [7:0] size_code(input int unsigned mb);
        if (mb >= 256)      return 8'h10;
        else if (mb >= 128) return 8'h0C;
        else if (mb >= 64)  return 8'h08;
        else if (mb >= 32)  return 8'h04;
        else                return 8'h00;
    endfunction

    // presence-detect byte carrying the density
    function automatic logic [7:0] spd_density(input int unsigned mb);
        if (mb >= 256)      return 8'd64;
        else if (mb >= 128) return 8'd32;
        else if (mb >= 64)  return 8'd16;
        else if (mb >= 32)  return 8'd4;
        else                return 8'd2;
    endfunction

    function automatic logic [7:0] spd_fixed(input int unsigned idx);
        case (idx)
            0:  return 8'h80;  1:  return 8'h08;  2:  return 8'h04;  3:  return 8'h0B;
            4:  return 8'h09;  5:  return 8'h01;  6:  return 8'h40;  8:  return 8'h02;
            9:  return 8'hA0;  10: return 8'hA0;  13: return 8'h08;  15: return 8'h01;
            16: return 8'h0E;  17: return 8'h04;  18: return 8'h1C;  19: return 8'h01;
            20: return 8'h02;  21: return 8'h20;  22: return 8'hC0;  27: return 8'h30;
            28: return 8'h28;  29: return 8'h30;  30: return 8'h28;
            default: return 8'h00;
        endcase
    endfunction

    typedef struct packed {
        logic [31:0] osc;
        logic [31:0] auxosc;
        logic [31:0] sdram;
        logic [31:0] init;
        logic [15:0] lock;
        logic        led;
        logic        remap;
        logic        rst_req;
        logic [31:0] rdata;
    } regs_t;

endpackage

// File: rtl/cmctl_spd_rom.sv
module cmctl_spd_rom #(
    parameter int unsigned MEM_MB  = 128,
    parameter int unsigned ENTRIES = cmctl_pkg::SPD_ENTRIES,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             in_table,
    output logic [7:0]       data
);
    logic [7:0] table_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        if (g == ENTRIES - 1) begin : g_density
            assign table_q[g] = cmctl_pkg::spd_density(MEM_MB);
        end else begin : g_fixed
            assign table_q[g] = cmctl_pkg::spd_fixed(g);
        end
    end

    assign data = in_table ? table_q[idx] : 8'h00;
endmodule

// File: rtl/cmctl_flag_pair.sv
module cmctl_flag_pair #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] flags
);
    logic [WIDTH-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (set_en) flags_d = flags_d | wdata;
        if (clr_en) flags_d = flags_d & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/core_ctrl_regs.sv
module core_ctrl_regs #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned MEM_MB = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              reset_req,
    output logic              remap_ram
);
    import cmctl_pkg::*;

    localparam int unsigned SPD_IDX_W   = $clog2(SPD_ENTRIES);
    localparam int unsigned NUM_FLAGS   = 2;
    localparam logic [31:0] SDRAM_RST   = SDRAM_BASE | {24'h0, size_code(MEM_MB)};

    regs_t       r_d, r_q;
    int unsigned word_idx;
    logic        win_hit;
    logic        win_table;
    logic [7:0]  spd_byte;
    logic        unlocked;
    logic [31:0] rd_val;
    logic        flag_set [NUM_FLAGS];
    logic        flag_clr [NUM_FLAGS];
    logic [31:0] flag_val [NUM_FLAGS];

    assign word_idx  = 32'(bus_addr[ADDR_W-1:2]);
    assign win_hit   = (bus_addr[ADDR_W-1:8] == (ADDR_W-8)'(1));
    assign win_table = win_hit && !bus_addr[7];
    assign unlocked  = (r_q.lock == UNLOCK_KEY);

    cmctl_spd_rom #(.MEM_MB(MEM_MB), .ENTRIES(SPD_ENTRIES)) u_spd (
        .idx      (bus_addr[SPD_IDX_W+1:2]),
        .in_table (win_table),
        .data     (spd_byte)
    );

    // two set/clear flag registers: general and non-volatile
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flags
        localparam int unsigned SET_W = (g == 0) ? W_FLG_SET : W_NVF_SET;
        localparam int unsigned CLR_W = (g == 0) ? W_FLG_CLR : W_NVF_CLR;
        assign flag_set[g] = bus_wr && !win_hit && (word_idx == SET_W);
        assign flag_clr[g] = bus_wr && !win_hit && (word_idx == CLR_W);
        cmctl_flag_pair #(.WIDTH(32)) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (flag_set[g]),
            .clr_en (flag_clr[g]),
            .wdata  (bus_wdata),
            .flags  (flag_val[g])
        );
    end

    // read multiplexer
    always_comb begin
        rd_val = 32'h0;
        if (win_hit) begin
            rd_val = {24'h0, spd_byte};
        end else begin
            case (word_idx)
                W_ID:      rd_val = ID_VALUE;
                W_OSC:     rd_val = r_q.osc;
                W_CTRL:    rd_val = {29'h0, r_q.remap, 1'b0, r_q.led};
                W_STAT:    rd_val = STAT_VALUE;
                W_LOCK:    rd_val = unlocked ? {15'h0, 1'b1, r_q.lock} : {16'h0, r_q.lock};
                W_AUXOSC:  rd_val = r_q.auxosc;
                W_SDRAM:   rd_val = r_q.sdram;
                W_INIT:    rd_val = r_q.init;
                W_FLG_SET: rd_val = flag_val[0];
                W_NVF_SET: rd_val = flag_val[1];
                default:   rd_val = 32'h0;
            endcase
        end
    end

    // next-state
    always_comb begin
        r_d         = r_q;
        r_d.rst_req = 1'b0;
        if (bus_wr && !win_hit) begin
            case (word_idx)
                W_OSC:    if (unlocked) r_d.osc = bus_wdata;
                W_AUXOSC: if (unlocked) r_d.auxosc = bus_wdata;
                W_CTRL: begin
                    r_d.led     = bus_wdata[0];
                    r_d.remap   = bus_wdata[2];
                    r_d.rst_req = bus_wdata[3];
                end
                W_LOCK:   r_d.lock  = bus_wdata[15:0];
                W_SDRAM:  r_d.sdram = bus_wdata;
                W_INIT:   r_d.init  = bus_wdata;
                default:  ;
            endcase
        end
        if (bus_rd) r_d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.osc     <= OSC_RST;
            r_q.auxosc  <= AUXOSC_RST;
            r_q.sdram   <= SDRAM_RST;
            r_q.init    <= INIT_RST;
            r_q.lock    <= '0;
            r_q.led     <= 1'b0;
            r_q.remap   <= 1'b0;
            r_q.rst_req <= 1'b0;
            r_q.rdata   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata = r_q.rdata;
    assign reset_req = r_q.rst_req;
    assign remap_ram = r_q.remap;
endmodule

// File: rtl/cmctl_checker.sv
module cmctl_checker #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic              reset_req,
    input logic              remap_ram
);
    logic [ADDR_W-3:0] word;
    assign word = bus_addr[ADDR_W-1:2];

    // R1: read data only changes after a read strobe
    a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R1: identity word
    a_r1_id_value: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && word == '0) |=> (bus_rdata == 32'h411A_3001));

    // R3: lock readback is at most 17 bits wide
    a_r3_lock_width: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && word == (ADDR_W-2)'(5)) |=> (bus_rdata[31:17] == 15'h0));

    // R5: reset request lasts one cycle
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    // R5: reset request follows a write with bit 3 set
    a_r5_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> ($past(bus_wr) && $past(bus_wdata[3])));

    // R6: remap level only moves after a write
    a_r6_remap_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(remap_ram));
endmodule

bind core_ctrl_regs cmctl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .reset_req (reset_req),
    .remap_ram (remap_ram)
);

// File: tb/core_ctrl_regs_tb.sv
module core_ctrl_regs_tb;
    localparam int unsigned ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_rdata;
    logic              reset_req;
    logic              remap_ram;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    core_ctrl_regs #(.ADDR_W(ADDR_W), .MEM_MB(128)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .reset_req(reset_req), .remap_ram(remap_ram)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset;
        chk("R5 reset_req idle", {31'h0, reset_req}, 32'h0);
        chk("R6 remap after reset", {31'h0, remap_ram}, 32'h0);
        rd_chk("R2 osc", 12'h008, 32'h0100_0048);
        rd_chk("R2 auxosc", 12'h01C, 32'h0007_FEFF);
        rd_chk("R2 init", 12'h024, 32'h0000_0112);
        rd_chk("R2 sdram size code", 12'h020, 32'h0001_112E);
        rd_chk("R2 ctrl", 12'h00C, 32'h0);
        rd_chk("R2 lock", 12'h014, 32'h0);
        rd_chk("R2 flags", 12'h030, 32'h0);
        rd_chk("R2 nvflags", 12'h038, 32'h0);
    endtask

    task automatic t_ident;
        logic [31:0] v;
        rd_chk("R1 id", 12'h000, 32'h411A_3001);
        rd_chk("R1 proc", 12'h004, 32'h0);
        rd_chk("R1 status", 12'h010, 32'h0010_0000);
        rd(12'h000, v);
        repeat (3) @(negedge clk);
        chk("R1 rdata holds", bus_rdata, 32'h411A_3001);
    endtask

    task automatic t_lock;
        wr(12'h014, 32'h1234_5678);
        rd_chk("R3 lock low half", 12'h014, 32'h0000_5678);
        wr(12'h014, 32'hFFFF_A05F);
        rd_chk("R3 lock key view", 12'h014, 32'h0001_A05F);
        wr(12'h008, 32'hDEAD_BEEF);
        wr(12'h01C, 32'h0BAD_F00D);
        rd_chk("R4 osc unlocked write", 12'h008, 32'hDEAD_BEEF);
        rd_chk("R4 aux unlocked write", 12'h01C, 32'h0BAD_F00D);
        wr(12'h014, 32'h0000_A05E);
        wr(12'h008, 32'h0000_0055);
        wr(12'h01C, 32'h0000_0066);
        rd_chk("R4 osc locked drop", 12'h008, 32'hDEAD_BEEF);
        rd_chk("R4 aux locked drop", 12'h01C, 32'h0BAD_F00D);
        rd_chk("R3 lock near key", 12'h014, 32'h0000_A05E);
    endtask

    task automatic t_ctrl;
        wr(12'h00C, 32'hFFFF_FFFF);
        chk("R5 reset pulse high", {31'h0, reset_req}, 32'h1);
        chk("R6 remap set", {31'h0, remap_ram}, 32'h1);
        @(negedge clk);
        chk("R5 reset pulse ends", {31'h0, reset_req}, 32'h0);
        rd_chk("R5 ctrl stored bits", 12'h00C, 32'h5);
        wr(12'h00C, 32'h0000_0001);
        chk("R5 no pulse without bit3", {31'h0, reset_req}, 32'h0);
        chk("R6 remap cleared", {31'h0, remap_ram}, 32'h0);
        rd_chk("R5 ctrl led only", 12'h00C, 32'h1);
    endtask

    task automatic t_flags;
        wr(12'h030, 32'h0000_00F0);
        wr(12'h030, 32'h0000_0F00);
        rd_chk("R7 flags set or", 12'h030, 32'h0000_0FF0);
        wr(12'h034, 32'h0000_0330);
        rd_chk("R7 flags clear", 12'h030, 32'h0000_0CC0);
        wr(12'h038, 32'h8000_0001);
        rd_chk("R8 nvflags set", 12'h038, 32'h8000_0001);
        rd_chk("R8 flags independent", 12'h030, 32'h0000_0CC0);
        wr(12'h03C, 32'h0000_0001);
        rd_chk("R8 nvflags clear", 12'h038, 32'h8000_0000);
    endtask

    task automatic t_sdram_init;
        wr(12'h020, 32'hA5A5_5A5A);
        wr(12'h024, 32'h1357_9BDF);
        rd_chk("R9 sdram write", 12'h020, 32'hA5A5_5A5A);
        rd_chk("R9 init write", 12'h024, 32'h1357_9BDF);
    endtask

    task automatic t_spd;
        rd_chk("R10 spd byte 0", 12'h100, 32'h80);
        rd_chk("R10 spd byte 9", 12'h124, 32'hA0);
        rd_chk("R10 spd byte 18", 12'h148, 32'h1C);
        rd_chk("R10 spd byte 22", 12'h158, 32'hC0);
        rd_chk("R10 spd density", 12'h17C, 32'd32);
        rd_chk("R10 upper window", 12'h180, 32'h0);
        rd_chk("R10 window end", 12'h1FC, 32'h0);
        wr(12'h104, 32'hFFFF_FFFF);
        rd_chk("R10 window write ignored", 12'h104, 32'h08);
    endtask

    task automatic t_unmapped;
        wr(12'h080, 32'hFFFF_FFFF);
        rd_chk("R11 voltage word", 12'h080, 32'h0);
        rd_chk("R11 voltage word 35", 12'h08C, 32'h0);
        wr(12'h040, 32'hFFFF_FFFF);
        rd_chk("R11 unassigned read", 12'h040, 32'h0);
        rd_chk("R11 word 6 zero", 12'h018, 32'h0);
        wr(12'h200, 32'hFFFF_FFFF);
        rd_chk("R11 flags untouched", 12'h030, 32'h0000_0CC0);
        rd_chk("R11 init untouched", 12'h024, 32'h1357_9BDF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ident();
        t_lock();
        t_ctrl();
        t_flags();
        t_sdram_init();
        t_spd();
        t_unmapped();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule